// File: doc/BRIEF.md
# UART Status Flag Controller

This block holds the status byte of a UART peripheral and the rules by which each of its flags is raised and dropped. The receiver, the transmitter, the start-edge detector and the auto-baud unit reach it only through single-cycle event strobes. Software reaches it through a small register bus that reads the status byte, reads the receive data address (only the pop side effect is modelled here) and writes the low transmit data address. An interrupt acknowledge input serves the transmit-complete vector.

Each flag has its own clear mechanism. The receive-complete flag follows buffer occupancy. The data-register-empty flag follows the transmit buffer. Transmit-complete is cleared by acknowledge or by writing one. Receive-start and inconsistent-sync are cleared only by writing one. Clearing inconsistent-sync also emits a one-cycle request that sends the receiver and auto-baud logic back to idle. Five interrupt requests come out, each a flag gated by its enable. Two spare status bits act as plain control bits.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the status byte reads 0x20: only the data-register-empty flag (bit 5) is set. All interrupt requests, both control bits and the idle request are 0.
- R2: The receive-complete flag (bit 7) is set the cycle after an rx_frame_done strobe while rx_enable is high. It is cleared by a read at address 1. When a frame strobe and that read fall in the same cycle, the flag stays set.
- R3: While rx_enable is low, the receive-complete flag is 0 from the next cycle on, and frame strobes are ignored.
- R4: The transmit-complete flag (bit 6) is set after tx_shift_done only if the data-register-empty flag is 1 and no write to address 2 occurs in that cycle. Otherwise the strobe has no effect.
- R5: The transmit-complete flag is cleared by txc_ack or by a status write with bit 6 at 1. A set event in the same cycle wins over either clear.
- R6: A write to address 2 clears the data-register-empty flag, and tx_buf_load sets it. When both occur in the same cycle, the write wins. A status write never changes this flag.
- R7: The receive-start flag (bit 4) is set by start_edge while both standby and start_det_en are high. It reads as 0 while start_det_en is low. Only a status write with bit 4 at 1 clears it, and a set event in the same cycle wins.
- R8: The inconsistent-sync flag (bit 3) is set when abaud_en and sync_time_bad are both high. It is also set when lin_auto and sync_char_valid are high and sync_char differs from 0x55. A sync character of 0x55 sets nothing.
- R9: A status write with bit 3 at 1 clears the inconsistent-sync flag, unless a set event occurs in the same cycle. Each such write makes rx_idle_req high for exactly the one cycle that follows it.
- R10: Status bits 1:0 are read/write control bits, driven on ctrl_bits. Bit 2 always reads 0. Writing 0 to any flag bit has no effect.
- R11: irq[4:0] equals {bit7, bit6, bit5, visible bit4, bit3} ANDed with int_en[4:0], in the same cycle. A flag that is not serviced keeps its request asserted on later cycles.
- R12: Address 0 is status (read/write), address 1 is receive data (read clears the receive flag), address 2 is transmit data low (write). bus_rdata shows the status byte when bus_addr is 0 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| rx_enable | input | 1 | Receiver enabled |
| rx_frame_done | input | 1 | Received byte placed in buffer |
| tx_buf_load | input | 1 | Transmit buffer moved to shifter |
| tx_shift_done | input | 1 | Frame fully shifted out |
| txc_ack | input | 1 | Transmit-complete vector acknowledged |
| standby | input | 1 | Device in standby |
| start_det_en | input | 1 | Start detection enabled |
| start_edge | input | 1 | Valid idle-to-start edge on receive line |
| abaud_en | input | 1 | Auto-baud enabled |
| sync_time_bad | input | 1 | Measured sync bit time out of range |
| lin_auto | input | 1 | LIN auto mode active |
| sync_char_valid | input | 1 | Sync character captured |
| sync_char | input | 8 | Captured sync character |
| int_en | input | 5 | Interrupt enables, same order as irq |
| irq | output | 5 | Interrupt requests |
| ctrl_bits | output | 2 | Status bits 1:0 |
| rx_idle_req | output | 1 | One-cycle return-to-idle request |

## Verification
Every flag, the control bits and the idle request are single registers, so a strobe or bus access applied before a rising edge is visible after that edge. bus_rdata and irq are combinational from those registers and from start_det_en and bus_addr, so they follow within the same cycle. The bench drives inputs just after a falling edge. It samples at the next falling edge, where a reference model has been advanced by exactly one edge. Directed checks change bus_addr or start_det_en between edges and read back at once, with no edge in between.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int STAT_W = 8;
  localparam int CTRL_W = 2;
  localparam int IRQ_W  = 5;
  localparam int ADDR_W = 2;

  // bit positions inside the status byte (software decodes these)
  localparam int B_RXC  = 7;
  localparam int B_TXC  = 6;
  localparam int B_DRE  = 5;
  localparam int B_RXS  = 4;
  localparam int B_ISF  = 3;
  localparam int B_RSV  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_RXDATA = 2'd1,
    REG_TXLO   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wr_status;
    logic wr_txlo;
    logic rd_rxdata;
  } bus_evt_t;
endpackage

// File: rtl/uart_flag_rst_sync.sv
module uart_flag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_flag_bus_dec.sv
module uart_flag_bus_dec
  import uart_flag_pkg::*;
(
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output bus_evt_t          evt
);
  always_comb begin
    evt           = '0;
    evt.wr_status = bus_wr && (bus_addr == REG_STATUS);
    evt.wr_txlo   = bus_wr && (bus_addr == REG_TXLO);
    evt.rd_rxdata = bus_rd && (bus_addr == REG_RXDATA);
  end
endmodule

// File: rtl/uart_flag_cell.sv
module uart_flag_cell #(
  parameter bit RST_VAL  = 1'b0,
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic upd;

  assign upd = set_i | clr_i;

  generate
    if (SET_WINS) begin : g_set_prio
      always_comb begin
        if (set_i)      q_d = 1'b1;
        else if (clr_i) q_d = 1'b0;
        else            q_d = q_o;
      end
      // R5
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    end else begin : g_clr_prio
      always_comb begin
        if (clr_i)      q_d = 1'b0;
        else if (set_i) q_d = 1'b1;
        else            q_d = q_o;
      end
      // R6
      clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_o <= RST_VAL;
    else if (upd) q_o <= q_d;
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/uart_flag_sync_chk.sv
module uart_flag_sync_chk #(
  parameter int          CHAR_W    = 8,
  parameter [CHAR_W-1:0] SYNC_CHAR = 8'h55
) (
  input  logic              abaud_en,
  input  logic              sync_time_bad,
  input  logic              lin_auto,
  input  logic              sync_char_valid,
  input  logic [CHAR_W-1:0] sync_char,
  output logic              fault_o
);
  logic time_fault;
  logic char_fault;

  always_comb begin
    time_fault = abaud_en && sync_time_bad;
    char_fault = lin_auto && sync_char_valid && (sync_char != SYNC_CHAR);
    fault_o    = time_fault || char_fault;
  end
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int          SYNC_W    = 8,
  parameter [SYNC_W-1:0] SYNC_CHAR = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [STAT_W-1:0] bus_rdata,
  input  logic              rx_enable,
  input  logic              rx_frame_done,
  input  logic              tx_buf_load,
  input  logic              tx_shift_done,
  input  logic              txc_ack,
  input  logic              standby,
  input  logic              start_det_en,
  input  logic              start_edge,
  input  logic              abaud_en,
  input  logic              sync_time_bad,
  input  logic              lin_auto,
  input  logic              sync_char_valid,
  input  logic [SYNC_W-1:0] sync_char,
  input  logic [IRQ_W-1:0]  int_en,
  output logic [IRQ_W-1:0]  irq,
  output logic [CTRL_W-1:0] ctrl_bits,
  output logic              rx_idle_req
);
  logic     rst_sn;
  bus_evt_t evt;

  logic rxc_q, txc_q, dre_q, rxs_q, isf_q;
  logic rxc_set, rxc_clr, txc_set, txc_clr, dre_set, dre_clr;
  logic rxs_set, rxs_clr, isf_set, isf_clr;
  logic rxs_vis;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              idle_q, idle_d;
  logic [STAT_W-1:0] status_rd;
  logic              unused_wdata;

  uart_flag_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sn)
  );

  uart_flag_bus_dec u_dec (
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .evt      (evt)
  );

  uart_flag_sync_chk #(.CHAR_W(SYNC_W), .SYNC_CHAR(SYNC_CHAR)) u_sync (
    .abaud_en        (abaud_en),
    .sync_time_bad   (sync_time_bad),
    .lin_auto        (lin_auto),
    .sync_char_valid (sync_char_valid),
    .sync_char       (sync_char),
    .fault_o         (isf_set)
  );

  // set/clear terms for each flag
  always_comb begin
    rxc_set = rx_frame_done && rx_enable;
    rxc_clr = evt.rd_rxdata || !rx_enable;
    dre_set = tx_buf_load;
    dre_clr = evt.wr_txlo;
    txc_set = tx_shift_done && dre_q && !evt.wr_txlo;
    txc_clr = txc_ack || (evt.wr_status && bus_wdata[B_TXC]);
    rxs_set = start_edge && standby && start_det_en;
    rxs_clr = evt.wr_status && bus_wdata[B_RXS];
    isf_clr = evt.wr_status && bus_wdata[B_ISF];
  end

  uart_flag_cell #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_rxc (
    .clk (clk), .rst_n (rst_sn), .set_i (rxc_set), .clr_i (rxc_clr), .q_o (rxc_q));
  uart_flag_cell #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_txc (
    .clk (clk), .rst_n (rst_sn), .set_i (txc_set), .clr_i (txc_clr), .q_o (txc_q));
  uart_flag_cell #(.RST_VAL(1'b1), .SET_WINS(1'b0)) u_dre (
    .clk (clk), .rst_n (rst_sn), .set_i (dre_set), .clr_i (dre_clr), .q_o (dre_q));
  uart_flag_cell #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_rxs (
    .clk (clk), .rst_n (rst_sn), .set_i (rxs_set), .clr_i (rxs_clr), .q_o (rxs_q));
  uart_flag_cell #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_isf (
    .clk (clk), .rst_n (rst_sn), .set_i (isf_set), .clr_i (isf_clr), .q_o (isf_q));

  // control bits and idle request: next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (evt.wr_status) ctrl_d = bus_wdata[CTRL_W-1:0];
    idle_d = isf_clr;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q <= '0;
      idle_q <= 1'b0;
    end else begin
      if (evt.wr_status) ctrl_q <= ctrl_d;
      idle_q <= idle_d;
    end
  end

  // read path and requests
  always_comb begin
    rxs_vis          = rxs_q && start_det_en;
    status_rd        = '0;
    status_rd[B_RXC] = rxc_q;
    status_rd[B_TXC] = txc_q;
    status_rd[B_DRE] = dre_q;
    status_rd[B_RXS] = rxs_vis;
    status_rd[B_ISF] = isf_q;
    status_rd[B_RSV] = 1'b0;
    status_rd[CTRL_W-1:0] = ctrl_q;
    bus_rdata = (bus_addr == REG_STATUS) ? status_rd : '0;
  end

  assign irq          = {rxc_q, txc_q, dre_q, rxs_vis, isf_q} & int_en;
  assign ctrl_bits    = ctrl_q;
  assign rx_idle_req  = idle_q;
  assign unused_wdata = ^{bus_wdata[B_RXC], bus_wdata[B_DRE], bus_wdata[B_RSV]};

  // R3
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !rx_enable |=> !rxc_q);

  // R4
  txc_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(txc_q) |-> $past(tx_shift_done && dre_q));

  // R6
  dre_status_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (evt.wr_status && !tx_buf_load) |=> $stable(dre_q));

  // R7
  rxs_mask_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !start_det_en |-> !bus_rdata[B_RXS] && !irq[1]);

  // R9
  idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_idle_req |-> $past(evt.wr_status && bus_wdata[B_ISF]));

  // R9
  isf_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (isf_clr && !isf_set) |=> !isf_q);

  // R11
  rxc_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq[4] && rx_enable && !evt.rd_rxdata) |=> (irq[4] || !int_en[4]));
endmodule

// File: tb/uart_flag_ctrl_tb.sv
module uart_flag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       rx_enable = 1'b1, rx_frame_done = 1'b0, tx_buf_load = 1'b0;
  logic       tx_shift_done = 1'b0, txc_ack = 1'b0, standby = 1'b0;
  logic       start_det_en = 1'b0, start_edge = 1'b0, abaud_en = 1'b0;
  logic       sync_time_bad = 1'b0, lin_auto = 1'b0, sync_char_valid = 1'b0;
  logic [7:0] sync_char = 8'd0;
  logic [4:0] int_en = 5'd0;
  logic [4:0] irq;
  logic [1:0] ctrl_bits;
  logic       rx_idle_req;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic m_rxc = 0, m_txc = 0, m_dre = 1, m_rxs = 0, m_isf = 0, m_idle = 0;
  logic [1:0] m_ctrl = 2'd0;

  always #5 clk = ~clk;

  uart_flag_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .bus_rd (bus_rd), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .rx_enable (rx_enable), .rx_frame_done (rx_frame_done),
    .tx_buf_load (tx_buf_load), .tx_shift_done (tx_shift_done),
    .txc_ack (txc_ack), .standby (standby), .start_det_en (start_det_en),
    .start_edge (start_edge), .abaud_en (abaud_en),
    .sync_time_bad (sync_time_bad), .lin_auto (lin_auto),
    .sync_char_valid (sync_char_valid), .sync_char (sync_char),
    .int_en (int_en), .irq (irq), .ctrl_bits (ctrl_bits),
    .rx_idle_req (rx_idle_req)
  );

  function automatic logic [7:0] exp_status();
    return {m_rxc, m_txc, m_dre, m_rxs & start_det_en, m_isf, 1'b0, m_ctrl};
  endfunction

  function automatic logic [4:0] exp_irq();
    return {m_rxc, m_txc, m_dre, m_rxs & start_det_en, m_isf} & int_en;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // advance the model by one edge using the inputs currently applied
  task automatic model_step();
    logic wr_st, wr_tx, rd_rx, txs;
    wr_st = bus_wr && bus_addr == 2'd0;
    wr_tx = bus_wr && bus_addr == 2'd2;
    rd_rx = bus_rd && bus_addr == 2'd1;
    txs   = tx_shift_done && m_dre && !wr_tx;
    if (!rx_enable) m_rxc = 1'b0;
    else if (rx_frame_done) m_rxc = 1'b1;
    else if (rd_rx) m_rxc = 1'b0;
    if (txs) m_txc = 1'b1;
    else if (txc_ack || (wr_st && bus_wdata[6])) m_txc = 1'b0;
    if (wr_tx) m_dre = 1'b0;
    else if (tx_buf_load) m_dre = 1'b1;
    if (start_edge && standby && start_det_en) m_rxs = 1'b1;
    else if (wr_st && bus_wdata[4]) m_rxs = 1'b0;
    if ((abaud_en && sync_time_bad) ||
        (lin_auto && sync_char_valid && sync_char != 8'h55)) m_isf = 1'b1;
    else if (wr_st && bus_wdata[3]) m_isf = 1'b0;
    m_idle = wr_st && bus_wdata[3];
    if (wr_st) m_ctrl = bus_wdata[1:0];
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk("R12 rdata", bus_rdata, (bus_addr == 2'd0) ? exp_status() : 8'h00);
    chk("R11 irq", {3'b0, irq}, {3'b0, exp_irq()});
    chk("R10 ctrl", {6'b0, ctrl_bits}, {6'b0, m_ctrl});
    chk("R9 idle", {7'b0, rx_idle_req}, {7'b0, m_idle});
  endtask

  task automatic clr_strobes();
    bus_rd = 0; bus_wr = 0; rx_frame_done = 0; tx_buf_load = 0;
    tx_shift_done = 0; txc_ack = 0; start_edge = 0; sync_time_bad = 0;
    sync_char_valid = 0;
  endtask

  task automatic peek();
    clr_strobes();
    bus_addr = 2'd0;
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 status", bus_rdata, 8'h20);
    chk("R1 irq", {3'b0, irq}, 8'h00);
    chk("R1 idle/ctrl", {5'b0, rx_idle_req, ctrl_bits}, 8'h00);
    int_en = 5'h1F;

    // R2 receive complete
    rx_frame_done = 1; tick(); peek();
    chk("R2 set", bus_rdata, 8'hA0);
    chk("R11 irq rxc+dre", {3'b0, irq}, 8'h14);
    tick(); peek();
    chk("R11 unserviced held", {3'b0, irq}, 8'h14);
    bus_rd = 1; bus_addr = 2'd1; tick(); peek();
    chk("R2 read clears", bus_rdata, 8'h20);
    rx_frame_done = 1; bus_rd = 1; bus_addr = 2'd1; tick(); peek();
    chk("R2 set beats read", bus_rdata, 8'hA0);
    // R3 receiver disabled
    rx_enable = 0; tick(); peek();
    chk("R3 flush", bus_rdata, 8'h20);
    rx_frame_done = 1; tick(); peek();
    chk("R3 frame ignored", bus_rdata, 8'h20);
    rx_enable = 1;

    // R6 / R4 transmit side
    wr(2'd2, 8'h5A); tick(); peek();
    chk("R6 tx write clears", bus_rdata, 8'h00);
    tx_shift_done = 1; tick(); peek();
    chk("R4 no set while buffer full", bus_rdata, 8'h00);
    wr(2'd0, 8'h20); tick(); peek();
    chk("R6 status write no effect", bus_rdata, 8'h00);
    tx_buf_load = 1; tick(); peek();
    chk("R6 load sets", bus_rdata, 8'h20);
    tx_shift_done = 1; tick(); peek();
    chk("R4 txc set", bus_rdata, 8'h60);
    txc_ack = 1; tick(); peek();
    chk("R5 ack clears", bus_rdata, 8'h20);
    tx_shift_done = 1; tick(); peek();
    tx_shift_done = 1; wr(2'd0, 8'h40); tick(); peek();
    chk("R5 set beats w1c", bus_rdata, 8'h60);
    wr(2'd0, 8'h40); tick(); peek();
    chk("R5 w1c clears", bus_rdata, 8'h20);
    tx_buf_load = 1; wr(2'd2, 8'h11); tick(); peek();
    chk("R6 write beats load", bus_rdata, 8'h00);
    tx_buf_load = 1; tick(); peek();

    // R7 receive start
    standby = 1; start_det_en = 1; start_edge = 1; tick(); peek();
    chk("R7 set", bus_rdata, 8'h30);
    bus_rd = 1; bus_addr = 2'd1; tick(); peek();
    chk("R7 read no clear", bus_rdata, 8'h30);
    start_det_en = 0; #1;
    chk("R7 masked", bus_rdata, 8'h20);
    chk("R7 irq masked", {3'b0, irq}, 8'h04);
    start_det_en = 1; #1;
    chk("R7 kept", bus_rdata, 8'h30);
    wr(2'd0, 8'h10); tick(); peek();
    chk("R7 w1c", bus_rdata, 8'h20);
    standby = 0; start_edge = 1; tick(); peek();
    chk("R7 needs standby", bus_rdata, 8'h20);

    // R8 / R9 sync fault
    lin_auto = 1; sync_char_valid = 1; sync_char = 8'h55; tick(); peek();
    chk("R8 good sync", bus_rdata, 8'h20);
    sync_char_valid = 1; sync_char = 8'h54; tick(); peek();
    chk("R8 bad sync", bus_rdata, 8'h28);
    lin_auto = 0;
    wr(2'd0, 8'h08); tick(); peek();
    chk("R9 w1c", bus_rdata, 8'h20);
    chk("R9 idle pulse", {7'b0, rx_idle_req}, 8'h01);
    tick();
    chk("R9 pulse one cycle", {7'b0, rx_idle_req}, 8'h00);
    abaud_en = 1; sync_time_bad = 1; tick(); peek();
    chk("R8 time fault", bus_rdata, 8'h28);
    sync_time_bad = 1; wr(2'd0, 8'h08); tick(); peek();
    chk("R9 set beats w1c", bus_rdata, 8'h28);
    chk("R9 idle on w1c", {7'b0, rx_idle_req}, 8'h01);
    wr(2'd0, 8'h08); tick(); peek();
    abaud_en = 0;

    // R10 / R12
    wr(2'd0, 8'h07); tick(); peek();
    chk("R10 ctrl bits", bus_rdata, 8'h23);
    chk("R10 ctrl port", {6'b0, ctrl_bits}, 8'h03);
    for (int a = 1; a < 4; a++) begin
      bus_addr = a[1:0]; #1;
      chk("R12 non-status read", bus_rdata, 8'h00);
    end

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      r = $urandom; r2 = $urandom;
      rx_enable = (r[3:0] != 4'd0);
      rx_frame_done = r[4] & r[5];
      tx_buf_load = r[6] & r[7];
      tx_shift_done = r[8] & r[9];
      txc_ack = r[10] & r[11] & r[12];
      standby = r[13];
      start_det_en = r[14] | r[15];
      start_edge = r[16] & r[17];
      abaud_en = r[18];
      sync_time_bad = r[19] & r[20];
      lin_auto = r[21];
      sync_char_valid = r[22] & r[23];
      sync_char = r[24] ? 8'h55 : r2[31:24];
      bus_addr = r2[1:0];
      bus_wr = r2[2] & r2[3];
      bus_rd = r2[4];
      bus_wdata = r2[15:8];
      int_en = r2[20:16];
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule